// File: doc/BRIEF.md
# PHY Reset and Strap Sequencer

This block brings an external serial PHY out of reset from the FPGA side. The PHY shares some pins between two uses: while its global reset is held, they are strap inputs that choose an operating mode, and once the PHY runs, the same pins carry a receive-side electrical-idle status back to the FPGA. The sequencer drives the strap value onto those pins while the global reset is low. It releases the global reset while the strap is still driven, so that the PHY latches the intended mode. It then stops driving the pins (bus turnaround), waits at least one cycle, raises the PHY output-enable, and finally releases the PIPE-level reset that starts the parallel PHY interface.

Every gap between steps is a cycle-count parameter, and one counter times all of the gaps in turn. The power-good input is synchronised internally. When it drops at any point, every output goes back to its reset value, the pins go back to driving the strap, and the sequence starts again from the first step.

Top module: `phy_boot_seq`

## Requirements
- R1: While rst_ni is low: phy_rst_n_o=0, pin_drive_o all ones (1 = FPGA drives the pin), pin_o=0, phy_oe_o=0, pipe_rst_n_o=0, seq_done_o=0.
- R2: phy_rst_n_o rises exactly SYNC_STAGES+T_PWR_CYC clock edges after pwr_good_i rises. If pwr_good_i drops at any time before that, phy_rst_n_o stays low and the count starts again from zero at the next rise.
- R3: pin_drive_o is all ones whenever phy_rst_n_o is low. It stays all ones for T_HOLD_CYC edges after phy_rst_n_o rises, and then goes to all zeros.
- R4: phy_oe_o rises exactly T_TURN_CYC edges after pin_drive_o goes to zero, with a minimum of one edge. phy_oe_o is never high while pin_drive_o is non-zero or in the cycle right after it was non-zero.
- R5: pipe_rst_n_o and seq_done_o rise together, exactly T_PIPE_CYC edges after phy_oe_o rises, and only while phy_oe_o is high.
- R6: Once set, seq_done_o stays high together with pipe_rst_n_o and phy_oe_o for as long as power stays good.
- R7: While phy_rst_n_o is low, pin_o takes the value of strap_i one edge later. From the edge that raises phy_rst_n_o, pin_o holds the last captured value and ignores strap_i.
- R8: SYNC_STAGES+1 edges after pwr_good_i falls, all outputs are back at their R1 values, except pin_o, which again follows strap_i.
- R9: After a power-good drop, the next rise of pwr_good_i runs the whole sequence again with the same gaps as the first power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Power and reference clock present (asynchronous) |
| strap_i | input | STRAP_W | Strap value to present on the shared pins |
| phy_rst_n_o | output | 1 | PHY global reset, active low |
| phy_oe_o | output | 1 | PHY output-enable |
| pipe_rst_n_o | output | 1 | PIPE-level reset, active low |
| pin_drive_o | output | STRAP_W | Tristate control of the shared pins, 1 = driven by the FPGA |
| pin_o | output | STRAP_W | Output data for the shared pins |
| seq_done_o | output | 1 | Sequence complete |

## Verification
A clean power-up is run with two different strap values, and the delay of each step is measured in edges, so that a swapped or off-by-one gap shows up as a wrong count. Power-good is dropped in three places: during the strap-hold phase, after the sequence has finished, and as a one-cycle glitch during the initial wait. The first two show that reset back to idle takes priority over the step in progress. The glitch shows that the wait counter restarts from zero instead of resuming. The strap input is changed after the global reset is released, to confirm that the pins keep the captured value. A long idle period with power held low confirms that the sequence never starts on its own.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // global reset low, strap driven
    ST_HOLD = 3'd1,  // global reset high, strap still driven
    ST_TURN = 3'd2,  // pins released, output-enable low
    ST_ENA  = 3'd3,  // output-enable high, pipe reset low
    ST_DONE = 3'd4
  } seq_st_e;

  function automatic int unsigned at_least_one(int unsigned v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/boot_seq_sync.sv
`timescale 1ns/1ps
module boot_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < int'(N); i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[N-1];
endmodule

// File: rtl/boot_seq_timer.sv
`timescale 1ns/1ps
module boot_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i || hit_o) cnt_q <= '0;
    else if (en_i)          cnt_q <= cnt_q + 1'b1;
  end

  // R2: a gap never runs past its limit
  p_cnt_in_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < lim_i));
endmodule

// File: rtl/boot_seq_ctrl.sv
`timescale 1ns/1ps
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned T_PWR_CYC   = 4,
  parameter int unsigned T_HOLD_CYC  = 4,
  parameter int unsigned T_TURN_CYC  = 1,
  parameter int unsigned T_PIPE_CYC  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_ok_i,
  input  logic             hit_i,
  output logic             clr_o,
  output logic             en_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             phy_rst_n_o,
  output logic             drive_o,
  output logic             oe_o,
  output logic             pipe_rst_n_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] L_PWR  = CNT_W'(at_least_one(T_PWR_CYC));
  localparam logic [CNT_W-1:0] L_HOLD = CNT_W'(at_least_one(T_HOLD_CYC));
  localparam logic [CNT_W-1:0] L_TURN = CNT_W'(at_least_one(T_TURN_CYC));
  localparam logic [CNT_W-1:0] L_PIPE = CNT_W'(at_least_one(T_PIPE_CYC));

  seq_st_e st_q, st_d;
  logic    grst_q, drv_q, oe_q, pipe_q, done_q;

  always_comb begin
    lim_o = L_PWR;
    unique case (st_q)
      ST_IDLE: lim_o = L_PWR;
      ST_HOLD: lim_o = L_HOLD;
      ST_TURN: lim_o = L_TURN;
      ST_ENA:  lim_o = L_PIPE;
      default: lim_o = L_PWR;
    endcase
  end

  assign clr_o = !pwr_ok_i;
  assign en_o  = pwr_ok_i && (st_q != ST_DONE);

  always_comb begin
    st_d = st_q;
    if (!pwr_ok_i) begin
      st_d = ST_IDLE;
    end else if (hit_i) begin
      unique case (st_q)
        ST_IDLE: st_d = ST_HOLD;
        ST_HOLD: st_d = ST_TURN;
        ST_TURN: st_d = ST_ENA;
        ST_ENA:  st_d = ST_DONE;
        default: st_d = ST_DONE;
      endcase
    end
  end

  // outputs registered straight from the next state: no decode glitches at the pads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      grst_q <= 1'b0;
      drv_q  <= 1'b1;
      oe_q   <= 1'b0;
      pipe_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      grst_q <= (st_d != ST_IDLE);
      drv_q  <= (st_d == ST_IDLE) || (st_d == ST_HOLD);
      oe_q   <= (st_d == ST_ENA) || (st_d == ST_DONE);
      pipe_q <= (st_d == ST_DONE);
      done_q <= (st_d == ST_DONE);
    end
  end

  assign phy_rst_n_o  = grst_q;
  assign drive_o      = drv_q;
  assign oe_o         = oe_q;
  assign pipe_rst_n_o = pipe_q;
  assign done_o       = done_q;

  p_drive_in_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grst_q |-> drv_q);

  p_oe_dead_time_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> (!drv_q && !$past(drv_q)));

  p_pipe_after_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pipe_q) |-> (oe_q && grst_q));

  p_done_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && pwr_ok_i) |=> done_q);

  p_drop_to_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> (!grst_q && drv_q && !oe_q && !pipe_q && !done_q));
endmodule

// File: rtl/boot_seq_pins.sv
`timescale 1ns/1ps
module boot_seq_pins #(
  parameter int unsigned STRAP_W = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic               drive_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] pin_drive_o,
  output logic [STRAP_W-1:0] pin_o
);
  logic [STRAP_W-1:0] strap_q;

  for (genvar g = 0; g < int'(STRAP_W); g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        strap_q[g] <= 1'b0;
      else if (capture_i) strap_q[g] <= strap_i[g];
    end
    assign pin_drive_o[g] = drive_i;
    assign pin_o[g]       = strap_q[g];
  end

  // R7: strap frozen once the global reset is released
  p_strap_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && !$past(capture_i)) |-> $stable(strap_q));
endmodule

// File: rtl/phy_boot_seq.sv
`timescale 1ns/1ps
module phy_boot_seq
  import boot_seq_pkg::*;
#(
  parameter int unsigned STRAP_W     = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned T_PWR_CYC   = 500000,
  parameter int unsigned T_HOLD_CYC  = 100000,
  parameter int unsigned T_TURN_CYC  = 4,
  parameter int unsigned T_PIPE_CYC  = 100000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwr_good_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               phy_rst_n_o,
  output logic               phy_oe_o,
  output logic               pipe_rst_n_o,
  output logic [STRAP_W-1:0] pin_drive_o,
  output logic [STRAP_W-1:0] pin_o,
  output logic               seq_done_o
);
  localparam int unsigned MAX_GAP = max_of4(at_least_one(T_PWR_CYC), at_least_one(T_HOLD_CYC),
                                            at_least_one(T_TURN_CYC), at_least_one(T_PIPE_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_GAP + 1);

  logic             pwr_ok, hit, clr, en, drive, grst_n;
  logic [CNT_W-1:0] lim;

  boot_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pwr_good_i), .q_o(pwr_ok)
  );

  boot_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(en), .lim_i(lim), .hit_o(hit)
  );

  boot_seq_ctrl #(
    .CNT_W(CNT_W), .T_PWR_CYC(T_PWR_CYC), .T_HOLD_CYC(T_HOLD_CYC),
    .T_TURN_CYC(T_TURN_CYC), .T_PIPE_CYC(T_PIPE_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni, .pwr_ok_i(pwr_ok), .hit_i(hit), .clr_o(clr), .en_o(en), .lim_o(lim),
    .phy_rst_n_o(grst_n), .drive_o(drive), .oe_o(phy_oe_o),
    .pipe_rst_n_o(pipe_rst_n_o), .done_o(seq_done_o)
  );

  boot_seq_pins #(.STRAP_W(STRAP_W)) u_pins (
    .clk_i, .rst_ni, .capture_i(!grst_n), .drive_i(drive), .strap_i(strap_i),
    .pin_drive_o(pin_drive_o), .pin_o(pin_o)
  );

  assign phy_rst_n_o = grst_n;
endmodule

// File: tb/sim_phy_boot_seq.sv
`timescale 1ns/1ps
module sim_phy_boot_seq;
  localparam int W   = 2;
  localparam int SY  = 2;
  localparam int TP  = 20;
  localparam int TH  = 8;
  localparam int TT  = 3;
  localparam int TPP = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwr = 1'b0;
  logic [W-1:0] strap = 2'b10;
  logic         grst_n, oe, pipe_n, done;
  logic [W-1:0] drv, pin;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  phy_boot_seq #(
    .STRAP_W(W), .SYNC_STAGES(SY), .T_PWR_CYC(TP), .T_HOLD_CYC(TH),
    .T_TURN_CYC(TT), .T_PIPE_CYC(TPP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr), .strap_i(strap),
    .phy_rst_n_o(grst_n), .phy_oe_o(oe), .pipe_rst_n_o(pipe_n),
    .pin_drive_o(drv), .pin_o(pin), .seq_done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return grst_n;
      1: return drv[0];
      2: return oe;
      3: return pipe_n;
      default: return done;
    endcase
  endfunction

  // edges until output sel reaches val, sampled at negedges
  task automatic meas(input int sel, input logic val, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sig(sel) !== val && n < 500);
  endtask

  task automatic power_off();
    pwr = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 grst", grst_n, 0);
    chk("R1 drive", drv, 3);
    chk("R1 pin", pin, 0);
    chk("R1 oe", oe, 0);
    chk("R1 pipe", pipe_n, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_bringup(input logic [W-1:0] s);
    int n;
    strap = s;
    repeat (3) @(negedge clk);
    chk("R7 pin follows strap", pin, s);
    chk("R3 driven in reset", drv, 3);
    pwr = 1'b1;
    meas(0, 1'b1, n);
    chk("R2 grst latency", n, SY + TP);
    chk("R3 still driven at release", drv, 3);
    chk("R7 pin at release", pin, s);
    strap = ~s;
    meas(1, 1'b0, n);
    chk("R3 hold gap", n, TH);
    chk("R3 drive all off", drv, 0);
    chk("R7 pin frozen", pin, s);
    chk("R4 oe low at turn", oe, 0);
    meas(2, 1'b1, n);
    chk("R4 turn gap", n, TT);
    chk("R5 pipe low at oe", pipe_n, 0);
    meas(3, 1'b1, n);
    chk("R5 pipe gap", n, TPP);
    chk("R5 done with pipe", done, 1);
    repeat (30) @(negedge clk);
    chk("R6 done held", done, 1);
    chk("R6 pipe held", pipe_n, 1);
    chk("R6 oe held", oe, 1);
    chk("R7 pin still frozen", pin, s);
  endtask

  task automatic t_drop_hold();
    int n;
    power_off();
    strap = 2'b01;
    pwr = 1'b1;
    meas(0, 1'b1, n);
    chk("R2 grst latency", n, SY + TP);
    repeat (2) @(negedge clk);
    pwr = 1'b0;
    meas(0, 1'b0, n);
    chk("R8 drop latency in hold", n, SY + 1);
    chk("R8 drive back", drv, 3);
    chk("R8 oe low", oe, 0);
    chk("R8 pipe low", pipe_n, 0);
    strap = 2'b11;
    @(negedge clk);
    chk("R8 pin follows strap again", pin, 3);
    pwr = 1'b1;
    meas(0, 1'b1, n);
    chk("R9 grst latency after drop", n, SY + TP);
    meas(1, 1'b0, n);
    chk("R9 hold gap after drop", n, TH);
    meas(2, 1'b1, n);
    chk("R9 turn gap after drop", n, TT);
    meas(3, 1'b1, n);
    chk("R9 pipe gap after drop", n, TPP);
  endtask

  task automatic t_drop_done();
    int n;
    chk("R6 done before drop", done, 1);
    pwr = 1'b0;
    meas(4, 1'b0, n);
    chk("R8 drop latency from done", n, SY + 1);
    chk("R8 grst low", grst_n, 0);
    chk("R8 oe low", oe, 0);
    chk("R8 pipe low", pipe_n, 0);
    chk("R8 drive back", drv, 3);
  endtask

  task automatic t_glitch();
    int n;
    power_off();
    pwr = 1'b1;
    repeat (10) @(negedge clk);
    pwr = 1'b0;
    @(negedge clk);
    pwr = 1'b1;
    meas(0, 1'b1, n);
    chk("R2 count restarts after glitch", n, SY + TP);
  endtask

  task automatic t_no_power();
    power_off();
    repeat (100) @(negedge clk);
    chk("R2 no release without power", grst_n, 0);
    chk("R2 oe idle without power", oe, 0);
    chk("R3 driven without power", drv, 3);
  endtask

  initial begin
    #100000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_bringup(2'b10);
    power_off();
    t_bringup(2'b01);
    t_drop_done();
    t_drop_hold();
    t_glitch();
    t_no_power();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule